// File: doc/BRIEF.md
# Nibble-Organised Display RAM Writer

This block takes bytes handed over by a host front end, each tagged with a command/data flag, and stores them in a 4-bit-wide display RAM. The RAM holds segment patterns for an LCD driver with 32 segment lines and 4 common lines. Word n holds the four common-row bits for segment n. An internal write pointer selects where the data goes.

A data byte (flag low) is split into two nibbles. The upper nibble is stored at the pointer and the lower nibble at the pointer plus one, after which the pointer steps forward by two. A rewrite command (flag high, fixed code in the top bits) replaces the single nibble at the pointer and leaves the pointer where it is. Command bytes of any other kind are left to decoders elsewhere, and this block ignores them. The host can load the pointer directly. A display scanner reads any word through a synchronous read port.

The RAM is split into an even-address bank and an odd-address bank. Because a data byte always touches one even and one odd word, each bank sees at most one write per cycle, which keeps both banks inferable as block RAM.

Top module: `nib_ram_writer`

## Requirements
- R1: While `rst` is high at a clock edge, `rd_data` is 0 after that edge, and the write pointer is 0 after reset is released.
- R2: When `in_vld` is 1 and `in_cmd` is 0, `in_byte[7:4]` is written to the word at the pointer and `in_byte[3:0]` to the word at pointer+1 (mod 32), bit order kept (byte bit 7 and byte bit 3 each land in RAM bit 3).
- R3: After a data-mode write, the pointer is its old value plus 2, modulo 32.
- R4: When `in_vld` is 1, `in_cmd` is 1 and `in_byte[7:5]` is 3'b100 (bit 4 don't care), `in_byte[3:0]` is written to the word at the pointer only, and the pointer is unchanged.
- R5: When `in_vld` is 1, `in_cmd` is 1 and `in_byte[7:5]` is not 3'b100, no word is written and the pointer is unchanged.
- R6: When `in_vld` is 0, no word is written and the pointer is unchanged.
- R7: When `ptr_load` is 1, the pointer takes `ptr_val` at that edge and this overrides any advance. A write accepted in the same cycle uses the pointer value from before the load.
- R8: `rd_data` shows the word at the `rd_addr` that was sampled at the previous edge. A write at edge t is visible to a read sampled at edge t+1. A read sampled at the same edge as a write to that word returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Byte valid strobe |
| in_byte | input | 8 | Received byte |
| in_cmd | input | 1 | 1 = command byte, 0 = display data |
| ptr_load | input | 1 | Load the write pointer |
| ptr_val | input | 5 | Value to load into the pointer |
| rd_addr | input | 5 | Scanner read address |
| rd_data | output | 4 | Scanner read data, one cycle after the address |

## Verification
Writes, pointer loads and pointer advances all take effect at the edge that accepts the strobe. A read therefore has to present its address at the following edge, and the data appears on `rd_data` just after the edge that samples the address. The bench drives every input 1 ns after a rising edge and samples `rd_data` 1 ns after the edge that took the address. Each expected word therefore comes from a model state that already includes every write made at earlier edges. The read-during-write case is checked separately by presenting the address and the write at the same edge and expecting the old word.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_DATA    = 2'd1,
    OP_REWRITE = 2'd2
  } nrw_op_e;

  localparam int NRW_BANKS = 2;
endpackage

// File: rtl/nrw_ptr.sv
module nrw_ptr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr + ADDR_W'(2);
  end

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> ptr == $past(load_val));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> ptr == $past(ptr) + ADDR_W'(2));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(ptr));
endmodule

// File: rtl/nrw_decode.sv
module nrw_decode
  import nrw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4,
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] RW_CODE = 3'b100,
  localparam int BYTE_W  = 2 * NIB_W,
  localparam int BANK_AW = ADDR_W - 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          vld,
  input  logic                          cmd,
  input  logic [BYTE_W-1:0]             byte_in,
  input  logic [ADDR_W-1:0]             ptr,
  output logic [NRW_BANKS-1:0]          we,
  output logic [NRW_BANKS-1:0][BANK_AW-1:0] wa,
  output logic [NRW_BANKS-1:0][NIB_W-1:0]   wd,
  output logic                          adv
);
  nrw_op_e             op;
  logic [ADDR_W-1:0]   nxt;

  assign nxt = ptr + ADDR_W'(1);

  always_comb begin
    op = OP_NONE;
    if (vld) begin
      if (!cmd) op = OP_DATA;
      else if (byte_in[BYTE_W-1 -: CODE_W] == RW_CODE) op = OP_REWRITE;
    end
  end

  always_comb begin
    we = '0;
    wa = '0;
    wd = '0;
    case (op)
      OP_DATA: begin
        we[ptr[0]] = 1'b1;
        wa[ptr[0]] = ptr[ADDR_W-1:1];
        wd[ptr[0]] = byte_in[BYTE_W-1 -: NIB_W];
        we[nxt[0]] = 1'b1;
        wa[nxt[0]] = nxt[ADDR_W-1:1];
        wd[nxt[0]] = byte_in[NIB_W-1:0];
      end
      OP_REWRITE: begin
        we[ptr[0]] = 1'b1;
        wa[ptr[0]] = ptr[ADDR_W-1:1];
        wd[ptr[0]] = byte_in[NIB_W-1:0];
      end
      default: ;
    endcase
  end

  assign adv = (op == OP_DATA);

  assert_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (vld && !cmd) |-> $countones(we) == 2);
  assert_single_R4: assert property (@(posedge clk) disable iff (rst)
    (vld && cmd) |-> $onehot0(we));
  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !vld |-> (we == '0));
endmodule

// File: rtl/nrw_bank.sv
module nrw_bank #(
  parameter int AW    = 4,
  parameter int DW    = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= mem[ra];
  end

  assert_stored_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/nib_ram_writer.sv
module nib_ram_writer
  import nrw_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4,
  localparam int BYTE_W  = 2 * NIB_W,
  localparam int BANK_AW = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_cmd,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NIB_W-1:0]  rd_data
);
  logic [ADDR_W-1:0]                     ptr;
  logic                                  adv;
  logic [NRW_BANKS-1:0]                  we;
  logic [NRW_BANKS-1:0][BANK_AW-1:0]     wa;
  logic [NRW_BANKS-1:0][NIB_W-1:0]       wd;
  logic [NRW_BANKS-1:0][NIB_W-1:0]       q;
  logic                                  rd_sel;

  nrw_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .adv(adv), .ptr(ptr)
  );

  nrw_decode #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_dec (
    .clk(clk), .rst(rst), .vld(in_vld), .cmd(in_cmd), .byte_in(in_byte),
    .ptr(ptr), .we(we), .wa(wa), .wd(wd), .adv(adv)
  );

  for (genvar b = 0; b < NRW_BANKS; b++) begin : g_bank
    nrw_bank #(.AW(BANK_AW), .DW(NIB_W)) u_bank (
      .clk(clk), .rst(rst), .we(we[b]), .wa(wa[b]), .wd(wd[b]),
      .ra(rd_addr[ADDR_W-1:1]), .q(q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel <= 1'b0;
    else     rd_sel <= rd_addr[0];
  end

  assign rd_data = q[rd_sel];

  assert_rst_out_R1: assert property (@(posedge clk)
    rst |=> rd_data == '0);
  assert_rw_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_cmd && !ptr_load) |=> $stable(ptr));
endmodule

// File: tb/sim_nib_ram_writer.sv
`timescale 1ns/1ps
module sim_nib_ram_writer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_cmd = 1'b0;
  logic       ptr_load = 1'b0;
  logic [4:0] ptr_val = '0;
  logic [4:0] rd_addr = '0;
  logic [3:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_mem [32];
  int mptr = 0;

  always #2.5 clk = ~clk;

  nib_ram_writer u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte), .in_cmd(in_cmd),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic rd(input int a, output logic [3:0] d);
    rd_addr = 5'(a);
    tick();
    d = rd_data;
  endtask

  task automatic dump(input string req);
    logic [3:0] d;
    for (int a = 0; a < 32; a++) begin
      rd(a, d);
      chk(req, int'(d), int'(exp_mem[a]));
    end
  endtask

  task automatic put(input logic [7:0] b, input logic c);
    in_vld = 1'b1; in_byte = b; in_cmd = c;
    tick();
    in_vld = 1'b0;
    if (!c) begin
      exp_mem[mptr] = b[7:4];
      exp_mem[(mptr + 1) % 32] = b[3:0];
      mptr = (mptr + 2) % 32;
    end else if (b[7:5] == 3'b100) begin
      exp_mem[mptr] = b[3:0];
    end
  endtask

  task automatic load(input int p);
    ptr_load = 1'b1; ptr_val = 5'(p);
    tick();
    ptr_load = 1'b0;
    mptr = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic [7:0] b;
    int p0;
    repeat (3) tick();
    chk("R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    tick();

    // R1/R2/R3: fill from the reset pointer (must start at 0)
    for (int i = 0; i < 16; i++) put(8'((i * 37 + 11) & 255), 1'b0);
    dump("R1 R2 R3 fill from reset pointer");

    // R2 sweep of every start address, including wrap at 31
    for (int s = 0; s < 32; s++) begin
      load(s);
      b = 8'((s * 53 + 7) & 255);
      put(b, 1'b0);
      rd(s, d);           chk("R2 high nibble", int'(d), int'(b[7:4]));
      rd((s + 1) % 32, d); chk("R2 low nibble", int'(d), int'(b[3:0]));
      // R3: next write follows at start+2
      put(8'((s * 29 + 200) & 255), 1'b0);
    end
    dump("R2 R3 sweep");

    // R4 rewrite command at every address; pointer must stay put
    for (int a = 0; a < 32; a++) begin
      load(a);
      put({3'b100, 1'(a), 4'(a * 7 + 3)}, 1'b1);
      rd(a, d); chk("R4 rewrite nibble", int'(d), (a * 7 + 3) & 15);
      put(8'((a * 91 + 5) & 255), 1'b0);
      rd(a, d); chk("R4 pointer unchanged", int'(d), ((a * 91 + 5) & 255) >> 4);
    end
    dump("R4 neighbours intact");

    // R5 every non-rewrite command byte is ignored
    load(9);
    for (int v = 0; v < 256; v++) begin
      if (v[7:5] != 3'b100) put(8'(v), 1'b1);
    end
    dump("R5 no write");
    put(8'h3C, 1'b0);
    rd(9, d);  chk("R5 pointer unchanged", int'(d), 3);
    rd(10, d); chk("R5 pointer unchanged", int'(d), 12);

    // R6 strobe low: nothing happens
    load(20);
    for (int v = 0; v < 64; v++) begin
      in_vld = 1'b0; in_byte = 8'(v * 4 + 1); in_cmd = v[0];
      tick();
    end
    dump("R6 ignored when not valid");
    put(8'h5A, 1'b0);
    rd(20, d); chk("R6 pointer unchanged", int'(d), 5);

    // R7 load and write in the same cycle
    load(4);
    p0 = mptr;
    in_vld = 1'b1; in_byte = 8'hE1; in_cmd = 1'b0;
    ptr_load = 1'b1; ptr_val = 5'd30;
    tick();
    in_vld = 1'b0; ptr_load = 1'b0;
    exp_mem[p0] = 4'hE; exp_mem[p0 + 1] = 4'h1;
    mptr = 30;
    rd(4, d); chk("R7 write uses old pointer", int'(d), 14);
    rd(5, d); chk("R7 write uses old pointer", int'(d), 1);
    put(8'h96, 1'b0);
    rd(30, d); chk("R7 load wins over advance", int'(d), 9);
    rd(31, d); chk("R7 load wins over advance", int'(d), 6);
    dump("R7 contents");

    // R8 read in the same cycle as a write returns the old word
    load(12);
    rd_addr = 5'd12;
    in_vld = 1'b1; in_byte = 8'h7B; in_cmd = 1'b0;
    tick();
    in_vld = 1'b0;
    chk("R8 read-first", int'(rd_data), int'(exp_mem[12]));
    exp_mem[12] = 4'h7; exp_mem[13] = 4'hB; mptr = 14;
    tick();
    chk("R8 visible next edge", int'(rd_data), 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule